// File: doc/BRIEF.md
# Vector-Extension Prefix Field Decoder

This block sits in an instruction decode pipe right after the prefix scanner. When the scanner finds one of the three escape bytes that start a vector-extension prefix (C4, C5 or 8F), it passes that byte to this block and then the bytes that follow it, one per accepted handshake. With the escape byte it also passes the legacy and REX prefix flags already seen for the instruction. The block turns the inverted and one's-complement payload fields into plain values and reports them as one bundle, with a strobe, a form code and an undefined-instruction flag.

The two-byte form fills in its missing fields with fixed defaults. The 8F escape is ambiguous: when its map-select field is below 8, the byte is an ordinary POP whose ModRM byte has just been read, and the block reports this as a separate form with no vector fields. Whenever the 8F escape is read as an XOP prefix, its map-select value is 8 or more. Any forbidden prefix seen before a VEX or XOP prefix makes the instruction undefined. A reserved or unknown map in the three-byte VEX form does the same.

Top module: `vexd_decoder`

## Requirements
- R1: While reset is held and directly after it, out_valid is 0 and in_ready is 1.
- R2: In the idle state, a byte accepted with in_first low, or with in_first high and a value other than C4, C5 or 8F, starts no prefix and produces no output. The next escape byte is then decoded normally.
- R3: After C4, two payload bytes are accepted. From the first payload byte, out_ext_r, out_ext_x and out_ext_b are the inverse of bits 7, 6 and 5, and out_map equals bits 4:0. out_form is 0. out_valid is high for the cycle that follows the edge that accepted the last payload byte.
- R4: For the three-byte forms, the second payload byte gives out_w = bit 7, out_vreg = the inverse of bits 6:3 (so 1111 gives register 0), out_vlen = bit 2 (0 for 128 bits, 1 for 256 bits) and out_pp = bits 1:0 (0 none, 1 = 66, 2 = F3, 3 = F2).
- R5: After C5, one payload byte is accepted. It gives out_ext_r as the inverse of bit 7, and out_vreg, out_vlen and out_pp in the same bit positions as R4. The block reports out_ext_x=0, out_ext_b=0, out_w=0, out_map=1 and out_form=1.
- R6: After 8F, if the first following byte has bits 4:0 below 8, the result comes after that single byte. It has out_form=3, out_undef=0 and all vector fields zero, whatever prefixes are present.
- R7: After 8F, if the first following byte has bits 4:0 of 8 or more, the block decodes as in R3 and R4 with out_form=2. The map value never makes this form undefined.
- R8: In the C4 form, a map value of 0 (reserved) or of 4 or more sets out_undef. The fields are still reported.
- R9: If any of pfx_66, pfx_f2, pfx_f3, pfx_lock or pfx_rex is high when the escape byte is accepted, the block sets out_undef for the VEX and XOP forms. Prefix inputs at any other time have no effect.
- R10: out_valid is a one-cycle pulse. in_ready is low during that cycle, and a byte offered then is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block takes the offered byte this cycle |
| in_first | input | 1 | The offered byte is a candidate escape byte |
| in_byte | input | 8 | Instruction byte |
| pfx_66 | input | 1 | Operand-size prefix seen |
| pfx_f2 | input | 1 | F2 prefix seen |
| pfx_f3 | input | 1 | F3 prefix seen |
| pfx_lock | input | 1 | LOCK prefix seen |
| pfx_rex | input | 1 | REX prefix seen |
| out_valid | output | 1 | Result strobe |
| out_undef | output | 1 | Undefined-instruction flag |
| out_form | output | 2 | 0 three-byte VEX, 1 two-byte VEX, 2 XOP, 3 plain POP |
| out_ext_r | output | 1 | ModRM.reg extension, true polarity |
| out_ext_x | output | 1 | SIB.index extension, true polarity |
| out_ext_b | output | 1 | Base / r/m extension, true polarity |
| out_map | output | 5 | Opcode map select |
| out_w | output | 1 | W bit |
| out_vreg | output | 4 | Extra source register number 0 to 15 |
| out_vlen | output | 1 | Vector length, 0 = 128, 1 = 256 |
| out_pp | output | 2 | Implied SIMD prefix code |

## Verification
If the sequencer is in the wrong state, a result strobe comes one byte early or one byte late, or a payload byte is taken as a new escape. The next decoded bundle shows this at once as a wrong form code or as shifted fields. If the prefix flags or the first payload byte are latched at the wrong time, the undefined flag or the extension bits come out wrong on the very next strobe. The sweep covers every payload value of the two-byte form, every map value of the three-byte and 8F forms, and every prefix combination. An error in polarity or bit position therefore appears at the first strobe that reaches it.

// File: rtl/vexd_pkg.sv
package vexd_pkg;
  localparam int BYTE_W = 8;
  localparam int MAP_W  = 5;
  localparam int VREG_W = 4;
  localparam int PP_W   = 2;
  localparam int PFX_N  = 5;

  localparam logic [BYTE_W-1:0] ESC_VEX3 = 8'hC4;
  localparam logic [BYTE_W-1:0] ESC_VEX2 = 8'hC5;
  localparam logic [BYTE_W-1:0] ESC_XOP  = 8'h8F;

  localparam logic [MAP_W-1:0] XOP_MAP_MIN  = MAP_W'(8);
  localparam logic [MAP_W-1:0] VEX_MAP_LAST = MAP_W'(3);
  localparam logic [MAP_W-1:0] VEX2_MAP     = MAP_W'(1);

  typedef enum logic [1:0] {
    FORM_VEX3 = 2'd0,
    FORM_VEX2 = 2'd1,
    FORM_XOP  = 2'd2,
    FORM_POP  = 2'd3
  } form_e;

  typedef struct packed {
    logic              ext_r;
    logic              ext_x;
    logic              ext_b;
    logic [MAP_W-1:0]  map;
    logic              w;
    logic [VREG_W-1:0] vreg;
    logic              vlen;
    logic [PP_W-1:0]   pp;
  } fields_t;
endpackage

// File: rtl/vexd_ctrl.sv
module vexd_ctrl
  import vexd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              take_esc,
  output logic              take_b1,
  output logic              done,
  output form_e             form_fin
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT1, ST_WAIT2, ST_EMIT} st_e;

  st_e   st_q, st_d;
  form_e form_q, form_d;
  logic  accept, esc_hit, form_en;
  form_e esc_form;

  assign in_ready = (st_q != ST_EMIT);
  assign accept   = in_valid & in_ready;

  always_comb begin
    esc_hit  = 1'b1;
    esc_form = FORM_VEX3;
    case (in_byte)
      ESC_VEX3: esc_form = FORM_VEX3;
      ESC_VEX2: esc_form = FORM_VEX2;
      ESC_XOP:  esc_form = FORM_XOP;
      default:  esc_hit  = 1'b0;
    endcase
  end

  always_comb begin
    st_d     = st_q;
    form_d   = form_q;
    take_esc = 1'b0;
    take_b1  = 1'b0;
    done     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept && in_first && esc_hit) begin
          take_esc = 1'b1;
          form_d   = esc_form;
          st_d     = ST_WAIT1;
        end
      end
      ST_WAIT1: begin
        if (accept) begin
          take_b1 = 1'b1;
          if (form_q == FORM_VEX2) begin
            done = 1'b1;
            st_d = ST_EMIT;
          end else if (form_q == FORM_XOP && in_byte[MAP_W-1:0] < XOP_MAP_MIN) begin
            form_d = FORM_POP;
            done   = 1'b1;
            st_d   = ST_EMIT;
          end else begin
            st_d = ST_WAIT2;
          end
        end
      end
      ST_WAIT2: begin
        if (accept) begin
          done = 1'b1;
          st_d = ST_EMIT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign form_en  = take_esc | done;
  assign form_fin = form_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      form_q <= FORM_VEX3;
    end else begin
      st_q <= st_d;
      if (form_en) form_q <= form_d;
    end
  end

  // R10
  ready_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  // R2
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && in_valid && !in_first) |=> st_q == ST_IDLE);
endmodule

// File: rtl/vexd_unpack.sv
module vexd_unpack
  import vexd_pkg::*;
(
  input  form_e             form,
  input  logic [BYTE_W-1:0] b1,
  input  logic [BYTE_W-1:0] b2,
  output fields_t           fld
);
  always_comb begin
    fld = '0;
    case (form)
      FORM_VEX2: begin
        fld.ext_r = ~b1[7];
        fld.map   = VEX2_MAP;
        fld.vreg  = ~b1[6:3];
        fld.vlen  = b1[2];
        fld.pp    = b1[1:0];
      end
      FORM_VEX3, FORM_XOP: begin
        fld.ext_r = ~b1[7];
        fld.ext_x = ~b1[6];
        fld.ext_b = ~b1[5];
        fld.map   = b1[MAP_W-1:0];
        fld.w     = b2[7];
        fld.vreg  = ~b2[6:3];
        fld.vlen  = b2[2];
        fld.pp    = b2[1:0];
      end
      default: fld = '0;
    endcase
  end
endmodule

// File: rtl/vexd_legal.sv
module vexd_legal
  import vexd_pkg::*;
(
  input  form_e            form,
  input  logic [MAP_W-1:0] map,
  input  logic [PFX_N-1:0] pfx,
  output logic             undef
);
  logic map_bad;

  always_comb begin
    map_bad = 1'b0;
    if (form == FORM_VEX3)
      map_bad = (map == '0) || (map > VEX_MAP_LAST);
  end

  assign undef = (form != FORM_POP) && ((|pfx) || map_bad);
endmodule

// File: rtl/vexd_decoder.sv
module vexd_decoder
  import vexd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_first,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              pfx_66,
  input  logic              pfx_f2,
  input  logic              pfx_f3,
  input  logic              pfx_lock,
  input  logic              pfx_rex,
  output logic              out_valid,
  output logic              out_undef,
  output logic [1:0]        out_form,
  output logic              out_ext_r,
  output logic              out_ext_x,
  output logic              out_ext_b,
  output logic [MAP_W-1:0]  out_map,
  output logic              out_w,
  output logic [VREG_W-1:0] out_vreg,
  output logic              out_vlen,
  output logic [PP_W-1:0]   out_pp
);
  logic              take_esc, take_b1, done;
  form_e             form_fin;
  logic [PFX_N-1:0]  pfx_q;
  logic [BYTE_W-1:0] b1_q, b1_cur;
  fields_t           fld_d, fld_q;
  logic              undef_d, undef_q, valid_q;
  form_e             form_q;

  vexd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_byte(in_byte), .in_ready(in_ready), .take_esc(take_esc),
    .take_b1(take_b1), .done(done), .form_fin(form_fin)
  );

  assign b1_cur = take_b1 ? in_byte : b1_q;

  vexd_unpack u_unpack (
    .form(form_fin), .b1(b1_cur), .b2(in_byte), .fld(fld_d)
  );

  vexd_legal u_legal (
    .form(form_fin), .map(fld_d.map), .pfx(pfx_q), .undef(undef_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfx_q   <= '0;
      b1_q    <= '0;
      fld_q   <= '0;
      undef_q <= 1'b0;
      form_q  <= FORM_VEX3;
      valid_q <= 1'b0;
    end else begin
      valid_q <= done;
      if (take_esc) pfx_q <= {pfx_66, pfx_f2, pfx_f3, pfx_lock, pfx_rex};
      if (take_b1)  b1_q  <= in_byte;
      if (done) begin
        fld_q   <= fld_d;
        undef_q <= undef_d;
        form_q  <= form_fin;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_undef = undef_q;
  assign out_form  = form_q;
  assign out_ext_r = fld_q.ext_r;
  assign out_ext_x = fld_q.ext_x;
  assign out_ext_b = fld_q.ext_b;
  assign out_map   = fld_q.map;
  assign out_w     = fld_q.w;
  assign out_vreg  = fld_q.vreg;
  assign out_vlen  = fld_q.vlen;
  assign out_pp    = fld_q.pp;

  // R10
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6
  pop_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_form == 2'd3) |-> (!out_undef && out_map == '0 && out_vreg == '0));

  // R5
  short_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_form == 2'd1) |-> (out_map == VEX2_MAP && !out_ext_x && !out_ext_b && !out_w));

  // R7
  xop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_form == 2'd2) |-> out_map >= XOP_MAP_MIN);

  // R9
  pfx_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && form_fin != FORM_POP && (|pfx_q)) |=> out_undef);
endmodule

// File: tb/vexd_decoder_tb.sv
module vexd_decoder_tb;
  localparam int CLK_P = 10;

  logic       clk, rst_n;
  logic       in_valid, in_ready, in_first;
  logic [7:0] in_byte;
  logic       pfx_66, pfx_f2, pfx_f3, pfx_lock, pfx_rex;
  logic       out_valid, out_undef, out_ext_r, out_ext_x, out_ext_b, out_w, out_vlen;
  logic [1:0] out_form, out_pp;
  logic [4:0] out_map;
  logic [3:0] out_vreg;

  int checks = 0;
  int errors = 0;

  vexd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_byte(in_byte), .pfx_66(pfx_66), .pfx_f2(pfx_f2),
    .pfx_f3(pfx_f3), .pfx_lock(pfx_lock), .pfx_rex(pfx_rex),
    .out_valid(out_valid), .out_undef(out_undef), .out_form(out_form),
    .out_ext_r(out_ext_r), .out_ext_x(out_ext_x), .out_ext_b(out_ext_b),
    .out_map(out_map), .out_w(out_w), .out_vreg(out_vreg),
    .out_vlen(out_vlen), .out_pp(out_pp)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P*150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_pfx(input logic [4:0] p);
    {pfx_66, pfx_f2, pfx_f3, pfx_lock, pfx_rex} = p;
  endtask

  // drive one byte at a negedge once ready; sample 1 time unit after the accepting edge
  task automatic send(input logic [7:0] b, input logic first);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    in_first = first;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_first = 1'b0;
  endtask

  function automatic logic [18:0] expv(input logic [7:0] esc, input logic [7:0] b1,
                                       input logic [7:0] b2, input logic [4:0] p);
    logic [1:0] f; logic u, r, x, bb, w, l; logic [4:0] m; logic [3:0] v; logic [1:0] pp;
    f = 2'd0; u = 1'b0; r = 1'b0; x = 1'b0; bb = 1'b0; w = 1'b0; l = 1'b0;
    m = 5'd0; v = 4'd0; pp = 2'd0;
    if (esc == 8'hC5) begin
      f = 2'd1; r = !b1[7]; m = 5'd1; v = 4'd15 - b1[6:3]; l = b1[2]; pp = b1[1:0];
      u = (p != 0);
    end else if (esc == 8'h8F && b1[4:0] < 5'd8) begin
      f = 2'd3;
    end else begin
      f = (esc == 8'hC4) ? 2'd0 : 2'd2;
      r = !b1[7]; x = !b1[6]; bb = !b1[5]; m = b1[4:0];
      w = b2[7]; v = 4'd15 - b2[6:3]; l = b2[2]; pp = b2[1:0];
      u = (p != 0) || (esc == 8'hC4 && (m == 0 || m > 3));
    end
    return {f, u, r, x, bb, m, w, v, l, pp};
  endfunction

  function automatic logic [18:0] actv();
    return {out_form, out_undef, out_ext_r, out_ext_x, out_ext_b, out_map, out_w, out_vreg, out_vlen, out_pp};
  endfunction

  task automatic run(input logic [7:0] esc, input logic [7:0] b1, input logic [7:0] b2,
                     input logic [4:0] p, input string tag);
    logic [18:0] e;
    bit two;
    e = expv(esc, b1, b2, p);
    two = !(esc == 8'hC5 || (esc == 8'h8F && b1[4:0] < 5'd8));
    set_pfx(p);
    send(esc, 1'b1);
    set_pfx(5'd0);
    chk(out_valid == 1'b0, {tag, " no strobe after escape"}, 32'(out_valid), 32'd0);
    send(b1, 1'b0);
    if (two) begin
      chk(out_valid == 1'b0, {tag, " no strobe after first payload"}, 32'(out_valid), 32'd0);
      send(b2, 1'b0);
    end
    chk(out_valid == 1'b1 && actv() == e, {tag, " decoded bundle"}, {13'd0, actv()}, {13'd0, e});
    chk(in_ready == 1'b0, "R10 ready low during strobe", 32'(in_ready), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0; in_byte = 8'h00;
    set_pfx(5'd0);
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset state", {30'd0, out_valid, in_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 after release", {30'd0, out_valid, in_ready}, 32'd1);

    // R2: non-escape bytes and escape without in_first are ignored
    send(8'h90, 1'b1);
    chk(out_valid == 1'b0, "R2 non-escape byte", 32'(out_valid), 32'd0);
    send(8'hC4, 1'b0);
    chk(out_valid == 1'b0, "R2 escape without first", 32'(out_valid), 32'd0);
    send(8'hC5, 1'b0);
    chk(out_valid == 1'b0, "R2 second stray byte", 32'(out_valid), 32'd0);
    run(8'hC5, 8'h7A, 8'h00, 5'd0, "R2 decode after ignored bytes");

    // R5: every two-byte payload
    for (int i = 0; i < 256; i++) run(8'hC5, 8'(i), 8'h00, 5'd0, "R5 two-byte form");

    // R3 R4 R8: every map with a spread of second bytes
    for (int m = 0; m < 32; m++)
      for (int k = 0; k < 16; k++)
        run(8'hC4, 8'(m + 32 * (k % 8)), 8'(k * 17), 5'd0, "R3 R4 R8 three-byte form");

    // R6 R7: 8F with every map select
    for (int m = 0; m < 32; m++)
      for (int k = 0; k < 2; k++)
        run(8'h8F, 8'(m + 160 * k), 8'(8'h3C ^ (k * 8'hFF)), 5'd0, "R6 R7 8F form");

    // R9: every prefix combination on each form
    for (int p = 0; p < 32; p++) begin
      run(8'hC5, 8'hF9, 8'h00, 5'(p), "R9 prefix two-byte");
      run(8'hC4, 8'hE2, 8'h45, 5'(p), "R9 prefix three-byte");
      run(8'h8F, 8'h68, 8'hA1, 5'(p), "R9 prefix XOP");
      run(8'h8F, 8'hC3, 8'h00, 5'(p), "R9 R6 prefix on POP");
    end

    // R10: strobe lasts one cycle; a byte offered while not ready is not taken
    run(8'hC4, 8'hE1, 8'h7C, 5'd0, "R10 setup");
    @(negedge clk);
    chk(in_ready == 1'b0, "R10 not ready in strobe cycle", 32'(in_ready), 32'd0);
    in_valid = 1'b1; in_byte = 8'hC4; in_first = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0; in_first = 1'b0;
    chk(out_valid == 1'b0, "R10 strobe one cycle", 32'(out_valid), 32'd0);
    run(8'hC5, 8'hFF, 8'h00, 5'd0, "R10 offered byte not taken");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule